// File: doc/BRIEF.md
# Flash page-buffer write controller

This block lets firmware update on-chip flash one page at a time without disturbing the bytes it does not mean to change. The CPU sees four byte-wide registers. It clears a 16-byte staging buffer, loads the bytes it wants to change into any slots in any order, points the address registers at a page, and issues a combined erase-program command. Each slot in the buffer carries a flag that is set when that slot is loaded.

The controller then walks the slots in ascending order. For each flagged slot it issues an erase operation followed by a program operation on a simple flash-array port. Slots without a flag generate no activity at all. The length of each operation is modelled by a cycle counter, so the time the array is held busy is set by parameters.

While the sequence runs, a busy bit in the status register is set. Data and command writes made during that time are dropped. When the sequence ends, the flags clear and a completion bit is set.

Top module: `pgbuf_flash_ctrl`

## Requirements
- R1: After reset the status register, the address-low register and the address-high register read 0x00, and no flash request is raised.
- R2: A data-register write (register select 1) made while idle stores the byte in the slot given by address-low bits [3:0] and flags that slot. If the same slot is written again, the later value is the one programmed.
- R3: Each accepted data-register write increments address-low bits [3:0], and slot 15 wraps to slot 0. Address-low bits [7:4] never change on a data write. The new value reads back at register select 2.
- R4: Writing the load command (code 0x01) to register select 0 clears every buffer byte and every flag, so a following erase-program issues no flash operation.
- R5: The erase-program command (code 0x02) visits each flagged slot in ascending order. For each one it issues an erase (op 0) and then a program (op 1) carrying the slot's byte. Both use byte address {address-high, address-low[7:4], slot}. Unflagged slots get no operation.
- R6: The request and done strobes are one-cycle pulses. Done rises exactly ERASE_CYCLES cycles after an erase request and PROG_CYCLES cycles after a program request. Address, op and data are held in between.
- R7: Status bit 0 (busy) is set from command acceptance until the last flagged byte is finished. Status bit 1 (complete) is then set, and all flags are cleared, so a repeated erase-program issues nothing.
- R8: An accepted command write clears the status bits. Any code other than 0x01 or 0x02 sets status bit 2 (error) and starts no operation.
- R9: While busy, data-register writes and command writes have no effect. No slot is loaded, address-low does not move, no error is raised and no restart occurs.
- R10: The data register (select 1) reads as 0x00. Address-high (select 3) reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 command/status, 1 data, 2 address low, 3 address high |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| fl_req | output | 1 | One-cycle request to the flash array |
| fl_op | output | 1 | Operation: 0 erase, 1 program |
| fl_addr | output | 16 | Flash byte address |
| fl_data | output | 8 | Byte to program |
| fl_done | output | 1 | One-cycle pulse marking the end of the timed operation |

## Verification
The checker assumes that both cycle-count parameters are at least one. It also assumes that one register access arrives per cycle, so a data write and an address-low write never coincide. The bench meets both assumptions by using small cycle counts and driving one write per cycle from a single task.

Writes made while busy are a deliberate part of the stimulus. They are issued only in a dedicated collision case, whose page has its one flagged slot at the end so the sequence is still running when the writes land. Every other command is issued only after the bench has seen the busy bit clear.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
    typedef enum logic [1:0] {
        SEL_CMD  = 2'd0,
        SEL_DATA = 2'd1,
        SEL_ALO  = 2'd2,
        SEL_AHI  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        FOP_ERASE = 1'b0,
        FOP_PROG  = 1'b1
    } fop_e;

    localparam logic [7:0] CMD_LOAD       = 8'h01;
    localparam logic [7:0] CMD_ERASE_PROG = 8'h02;
endpackage

// File: rtl/pgbuf_store.sv
module pgbuf_store #(
    parameter int PAGE_BYTES = 16,
    parameter int SLOT_W     = $clog2(PAGE_BYTES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr_all,
    input  logic                        clr_flags,
    input  logic                        wr_en,
    input  logic [SLOT_W-1:0]           wr_slot,
    input  logic [7:0]                  wr_data,
    output logic [PAGE_BYTES-1:0][7:0]  bytes_o,
    output logic [PAGE_BYTES-1:0]       flags_o
);
    typedef struct packed {
        logic [PAGE_BYTES-1:0][7:0] bytes;
        logic [PAGE_BYTES-1:0]      flags;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_all) begin
            st_d.bytes = '0;
            st_d.flags = '0;
        end else begin
            if (clr_flags) begin
                st_d.flags = '0;
            end
            if (wr_en) begin
                st_d.bytes[wr_slot] = wr_data;
                st_d.flags[wr_slot] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bytes_o = st_q.bytes;
    assign flags_o = st_q.flags;
endmodule

// File: rtl/pgbuf_seq.sv
module pgbuf_seq
    import pgbuf_pkg::*;
#(
    parameter int PAGE_BYTES   = 16,
    parameter int SLOT_W       = $clog2(PAGE_BYTES),
    parameter int ADDR_W       = 16,
    parameter int ERASE_CYCLES = 250000,
    parameter int PROG_CYCLES  = 250000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [ADDR_W-SLOT_W-1:0]    page_i,
    input  logic [PAGE_BYTES-1:0]       flags_i,
    input  logic [PAGE_BYTES-1:0][7:0]  bytes_i,
    output logic                        busy_o,
    output logic                        finish_o,
    output logic                        fl_req_o,
    output logic                        fl_op_o,
    output logic [ADDR_W-1:0]           fl_addr_o,
    output logic [7:0]                  fl_data_o,
    output logic                        fl_done_o
);
    localparam int PAGE_W = ADDR_W - SLOT_W;
    localparam int MAXC   = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
    localparam int CNT_W  = $clog2(MAXC + 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(PAGE_BYTES - 1);
    localparam logic [CNT_W-1:0]  ERASE_LD  = CNT_W'(ERASE_CYCLES - 1);
    localparam logic [CNT_W-1:0]  PROG_LD   = CNT_W'(PROG_CYCLES - 1);

    typedef enum logic [1:0] {S_IDLE, S_SCAN, S_WAIT, S_NEXT} seq_st_e;

    typedef struct packed {
        seq_st_e             st;
        logic [SLOT_W-1:0]   slot;
        logic [PAGE_W-1:0]   page;
        logic [CNT_W-1:0]    cnt;
        logic                req;
        logic                done;
        fop_e                op;
        logic [ADDR_W-1:0]   addr;
        logic [7:0]          data;
    } seq_t;

    seq_t sq_d, sq_q;
    logic fin;

    always_comb begin
        sq_d      = sq_q;
        sq_d.req  = 1'b0;
        sq_d.done = 1'b0;
        fin       = 1'b0;
        unique case (sq_q.st)
            S_IDLE: begin
                if (start) begin
                    sq_d.st   = S_SCAN;
                    sq_d.slot = '0;
                    sq_d.page = page_i;
                end
            end
            S_SCAN: begin
                if (flags_i[sq_q.slot]) begin
                    sq_d.req  = 1'b1;
                    sq_d.op   = FOP_ERASE;
                    sq_d.addr = {sq_q.page, sq_q.slot};
                    sq_d.data = 8'hFF;
                    sq_d.cnt  = ERASE_LD;
                    sq_d.st   = S_WAIT;
                end else if (sq_q.slot == LAST_SLOT) begin
                    sq_d.st = S_IDLE;
                    fin     = 1'b1;
                end else begin
                    sq_d.slot = sq_q.slot + SLOT_W'(1);
                end
            end
            S_WAIT: begin
                if (sq_q.cnt == '0) begin
                    sq_d.done = 1'b1;
                    sq_d.st   = S_NEXT;
                end else begin
                    sq_d.cnt = sq_q.cnt - CNT_W'(1);
                end
            end
            S_NEXT: begin
                if (sq_q.op == FOP_ERASE) begin
                    sq_d.req  = 1'b1;
                    sq_d.op   = FOP_PROG;
                    sq_d.data = bytes_i[sq_q.slot];
                    sq_d.cnt  = PROG_LD;
                    sq_d.st   = S_WAIT;
                end else if (sq_q.slot == LAST_SLOT) begin
                    sq_d.st = S_IDLE;
                    fin     = 1'b1;
                end else begin
                    sq_d.slot = sq_q.slot + SLOT_W'(1);
                    sq_d.st   = S_SCAN;
                end
            end
            default: sq_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q <= '{st: S_IDLE, op: FOP_ERASE, default: '0};
        end else begin
            sq_q <= sq_d;
        end
    end

    assign busy_o    = (sq_q.st != S_IDLE);
    assign finish_o  = fin;
    assign fl_req_o  = sq_q.req;
    assign fl_op_o   = sq_q.op;
    assign fl_addr_o = sq_q.addr;
    assign fl_data_o = sq_q.data;
    assign fl_done_o = sq_q.done;
endmodule

// File: rtl/pgbuf_flash_ctrl.sv
module pgbuf_flash_ctrl
    import pgbuf_pkg::*;
#(
    parameter int PAGE_BYTES   = 16,
    parameter int ERASE_CYCLES = 250000,
    parameter int PROG_CYCLES  = 250000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_sel,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    output logic        fl_req,
    output logic        fl_op,
    output logic [15:0] fl_addr,
    output logic [7:0]  fl_data,
    output logic        fl_done
);
    localparam int SLOT_W = $clog2(PAGE_BYTES);
    localparam int ADDR_W = 16;
    localparam int PAGE_W = ADDR_W - SLOT_W;

    typedef struct packed {
        logic [7:0] alo;
        logic [7:0] ahi;
        logic       cmpl;
        logic       err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                        seq_busy;
    logic                        seq_finish;
    logic                        wr_cmd;
    logic                        wr_dat;
    logic                        load_clr;
    logic                        seq_start;
    logic [PAGE_W-1:0]           page_sel;
    logic [PAGE_BYTES-1:0][7:0]  buf_bytes;
    logic [PAGE_BYTES-1:0]       buf_flags;

    assign wr_cmd    = reg_we && (reg_sel == SEL_CMD)  && !seq_busy;
    assign wr_dat    = reg_we && (reg_sel == SEL_DATA) && !seq_busy;
    assign load_clr  = wr_cmd && (reg_wdata == CMD_LOAD);
    assign seq_start = wr_cmd && (reg_wdata == CMD_ERASE_PROG);
    assign page_sel  = {ctl_q.ahi, ctl_q.alo[7:SLOT_W]};

    always_comb begin
        ctl_d = ctl_q;
        if (seq_finish) begin
            ctl_d.cmpl = 1'b1;
        end
        if (wr_cmd) begin
            ctl_d.cmpl = 1'b0;
            ctl_d.err  = !((reg_wdata == CMD_LOAD) || (reg_wdata == CMD_ERASE_PROG));
        end
        if (wr_dat) begin
            ctl_d.alo[SLOT_W-1:0] = ctl_q.alo[SLOT_W-1:0] + SLOT_W'(1);
        end
        if (reg_we && (reg_sel == SEL_ALO)) begin
            ctl_d.alo = reg_wdata;
        end
        if (reg_we && (reg_sel == SEL_AHI)) begin
            ctl_d.ahi = reg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        unique case (reg_sel)
            SEL_CMD:  reg_rdata = {5'b0, ctl_q.err, ctl_q.cmpl, seq_busy};
            SEL_DATA: reg_rdata = 8'h00;
            SEL_ALO:  reg_rdata = ctl_q.alo;
            default:  reg_rdata = ctl_q.ahi;
        endcase
    end

    pgbuf_store #(
        .PAGE_BYTES (PAGE_BYTES),
        .SLOT_W     (SLOT_W)
    ) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_all   (load_clr),
        .clr_flags (seq_finish),
        .wr_en     (wr_dat),
        .wr_slot   (ctl_q.alo[SLOT_W-1:0]),
        .wr_data   (reg_wdata),
        .bytes_o   (buf_bytes),
        .flags_o   (buf_flags)
    );

    pgbuf_seq #(
        .PAGE_BYTES   (PAGE_BYTES),
        .SLOT_W       (SLOT_W),
        .ADDR_W       (ADDR_W),
        .ERASE_CYCLES (ERASE_CYCLES),
        .PROG_CYCLES  (PROG_CYCLES)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (seq_start),
        .page_i    (page_sel),
        .flags_i   (buf_flags),
        .bytes_i   (buf_bytes),
        .busy_o    (seq_busy),
        .finish_o  (seq_finish),
        .fl_req_o  (fl_req),
        .fl_op_o   (fl_op),
        .fl_addr_o (fl_addr),
        .fl_data_o (fl_data),
        .fl_done_o (fl_done)
    );
endmodule

// File: rtl/pgbuf_flash_ctrl_chk.sv
module pgbuf_flash_ctrl_chk #(
    parameter int SLOT_W = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic [1:0]  reg_sel,
    input logic        fl_req,
    input logic        fl_op,
    input logic [15:0] fl_addr,
    input logic        fl_done,
    input logic        busy,
    input logic [7:0]  alo,
    input logic        cmpl,
    input logic        err
);
    p_req_done_apart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_req && fl_done));

    p_port_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fl_req) |-> ($stable(fl_addr) && $stable(fl_op)));

    p_req_only_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req |-> busy);

    p_slot_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == 2'd1 && !busy) |=>
        ((alo[7:SLOT_W] == $past(alo[7:SLOT_W])) &&
         (alo[SLOT_W-1:0] == $past(alo[SLOT_W-1:0]) + SLOT_W'(1))));

    p_cmd_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == 2'd0 && !busy) |=> !cmpl);

    p_err_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);

    p_busy_data_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we && reg_sel == 2'd1) |=> (alo == $past(alo)));

    p_busy_cmd_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we && reg_sel == 2'd0) |=> !err);
endmodule

bind pgbuf_flash_ctrl pgbuf_flash_ctrl_chk #(.SLOT_W(SLOT_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .reg_we  (reg_we),
    .reg_sel (reg_sel),
    .fl_req  (fl_req),
    .fl_op   (fl_op),
    .fl_addr (fl_addr),
    .fl_done (fl_done),
    .busy    (seq_busy),
    .alo     (ctl_q.alo),
    .cmpl    (ctl_q.cmpl),
    .err     (ctl_q.err)
);

// File: tb/pgbuf_flash_ctrl_tb_top.sv
`timescale 1ns/1ps
module pgbuf_flash_ctrl_tb_top;
    localparam int EC = 3;
    localparam int PC = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        fl_req, fl_op, fl_done;
    logic [15:0] fl_addr;
    logic [7:0]  fl_data;

    int nchk = 0;
    int nerr = 0;
    int cyc = 0;
    int req_cyc = 0;
    logic cur_op = 1'b0;
    int ev_n = 0;
    logic        ev_op   [0:47];
    logic [15:0] ev_addr [0:47];
    logic [7:0]  ev_data [0:47];
    logic [7:0]  exp_d   [0:15];
    logic [7:0]  rv;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pgbuf_flash_ctrl #(.PAGE_BYTES(16), .ERASE_CYCLES(EC), .PROG_CYCLES(PC)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fl_req(fl_req),
        .fl_op(fl_op), .fl_addr(fl_addr), .fl_data(fl_data), .fl_done(fl_done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (fl_req) begin
            if (ev_n < 48) begin
                ev_op[ev_n]   = fl_op;
                ev_addr[ev_n] = fl_addr;
                ev_data[ev_n] = fl_data;
            end
            ev_n++;
            req_cyc = cyc;
            cur_op  = fl_op;
        end
        if (fl_done) begin
            check((cyc - req_cyc) == (cur_op ? PC : EC), "R6 done delay",
                  cyc - req_cyc, cur_op ? PC : EC);
            check(fl_op == cur_op, "R6 op held", fl_op, cur_op);
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [7:0] val);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [7:0] val);
        reg_sel = sel;
        #1;
        val = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int i = 0; i < 1000; i++) begin
            rd(2'd0, s);
            if (!s[0]) break;
            @(negedge clk);
        end
    endtask

    function automatic logic [7:0] val_of(input int s, input int seed);
        return 8'(s * 37 + seed);
    endfunction

    task automatic load_pattern(input logic [15:0] pat, input logic [3:0] nib, input int seed);
        for (int s = 0; s < 16; s++) begin
            if (pat[s]) begin
                wr(2'd2, {nib, 4'(s)});
                wr(2'd1, val_of(s, seed));
                exp_d[s] = val_of(s, seed);
            end
        end
    endtask

    task automatic check_events(input logic [15:0] pat, input logic [7:0] ahi, input logic [3:0] nib);
        int idx = 0;
        check(ev_n == 2 * $countones(pat), "R5 op count", ev_n, 2 * $countones(pat));
        for (int s = 0; s < 16; s++) begin
            if (pat[s] && idx + 1 < ev_n) begin
                check(ev_op[idx] == 1'b0 && ev_addr[idx] == {ahi, nib, 4'(s)},
                      "R5 erase op/addr", {15'(ev_op[idx]), ev_addr[idx]}, {ahi, nib, 4'(s)});
                idx++;
                check(ev_op[idx] == 1'b1 && ev_addr[idx] == {ahi, nib, 4'(s)},
                      "R5 program op/addr", {15'(ev_op[idx]), ev_addr[idx]}, {1'b1, ahi, nib, 4'(s)});
                check(ev_data[idx] == exp_d[s], "R2 programmed byte", ev_data[idx], exp_d[s]);
                idx++;
            end
        end
    endtask

    task automatic run_ep(input logic [15:0] pat, input logic [7:0] ahi, input logic [3:0] nib, input int seed);
        logic [7:0] s;
        wr(2'd0, 8'h01);
        wr(2'd3, ahi);
        load_pattern(pat, nib, seed);
        ev_n = 0;
        wr(2'd0, 8'h02);
        wait_idle();
        check_events(pat, ahi, nib);
        rd(2'd0, s);
        check(s == 8'h02, "R7 complete status", s, 8'h02);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        rd(2'd0, rv); check(rv == 8'h00, "R1 status", rv, 0);
        rd(2'd2, rv); check(rv == 8'h00, "R1 addr low", rv, 0);
        rd(2'd3, rv); check(rv == 8'h00, "R1 addr high", rv, 0);
        check(fl_req == 1'b0, "R1 request idle", fl_req, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 register readback
        wr(2'd3, 8'h5A);
        rd(2'd3, rv); check(rv == 8'h5A, "R10 addr high readback", rv, 8'h5A);
        wr(2'd1, 8'hC3);
        rd(2'd1, rv); check(rv == 8'h00, "R10 data reads zero", rv, 0);

        // R5 walking single slot sweep, plus multi-slot patterns
        for (int k = 0; k < 16; k++) run_ep(16'(1 << k), 8'(k * 9), 4'(k), k);
        run_ep(16'hFFFF, 8'h3C, 4'h7, 11);
        run_ep(16'hAAAA, 8'h81, 4'h2, 5);
        run_ep(16'h5555, 8'h42, 4'hD, 90);
        run_ep(16'h8001, 8'hFE, 4'hF, 200);
        run_ep(16'h0000, 8'h10, 4'h1, 1);
        run_ep(16'h3C96, 8'h07, 4'h9, 33);

        // R7 flags cleared at finish: repeat without reload
        ev_n = 0;
        wr(2'd0, 8'h02); wait_idle();
        check(ev_n == 0, "R7 flags cleared", ev_n, 0);
        rd(2'd0, rv); check(rv == 8'h02, "R7 complete again", rv, 8'h02);

        // R2 last write to a slot wins
        wr(2'd0, 8'h01); wr(2'd3, 8'h12);
        wr(2'd2, 8'h35); wr(2'd1, 8'h11);
        wr(2'd2, 8'h35); wr(2'd1, 8'h22);
        exp_d[5] = 8'h22;
        ev_n = 0; wr(2'd0, 8'h02); wait_idle();
        check_events(16'h0020, 8'h12, 4'h3);

        // R3 auto-increment wraps inside the page
        wr(2'd0, 8'h01); wr(2'd3, 8'h66); wr(2'd2, 8'hAE);
        wr(2'd1, 8'hE0); wr(2'd1, 8'hF0); wr(2'd1, 8'h00); wr(2'd1, 8'h10);
        rd(2'd2, rv); check(rv == 8'hA2, "R3 wrap readback", rv, 8'hA2);
        exp_d[14] = 8'hE0; exp_d[15] = 8'hF0; exp_d[0] = 8'h00; exp_d[1] = 8'h10;
        ev_n = 0; wr(2'd0, 8'h02); wait_idle();
        check_events(16'hC003, 8'h66, 4'hA);

        // R4 load clears contents and flags
        wr(2'd0, 8'h01); load_pattern(16'h0F0F, 4'h0, 3);
        wr(2'd0, 8'h01);
        ev_n = 0; wr(2'd0, 8'h02); wait_idle();
        check(ev_n == 0, "R4 load cleared flags", ev_n, 0);

        // R8 unknown command
        ev_n = 0; wr(2'd0, 8'h55);
        rd(2'd0, rv); check(rv == 8'h04, "R8 error status", rv, 8'h04);
        repeat (10) @(negedge clk);
        check(ev_n == 0, "R8 no operation", ev_n, 0);
        wr(2'd0, 8'h01);
        rd(2'd0, rv); check(rv == 8'h00, "R8 command clears status", rv, 0);

        // R9 writes while busy are dropped
        wr(2'd0, 8'h01); wr(2'd3, 8'h21); load_pattern(16'h8000, 4'h4, 7);
        wr(2'd2, 8'h43);
        ev_n = 0; wr(2'd0, 8'h02);
        rd(2'd0, rv); check(rv[0] == 1'b1, "R7 busy after accept", rv, 1);
        wr(2'd1, 8'h99);
        wr(2'd0, 8'h01);
        wr(2'd0, 8'h77);
        rd(2'd2, rv); check(rv == 8'h43, "R9 addr low unmoved", rv, 8'h43);
        wait_idle();
        check_events(16'h8000, 8'h21, 4'h4);
        rd(2'd0, rv); check(rv == 8'h02, "R9 no error or restart", rv, 8'h02);
        ev_n = 0; wr(2'd0, 8'h02); wait_idle();
        check(ev_n == 0, "R9 busy data write not loaded", ev_n, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule